// File: doc/BRIEF.md
# Nibble-Wide Receive Frame Check Sequence Verifier

This block verifies the 32-bit frame check sequence of a received Ethernet frame that arrives four bits at a time. An upstream stage has already removed preamble and start delimiter and delays the data so that a last-nibble pulse lines up with the final nibble of the frame. Every qualified nibble advances a CRC-32 register by four bit steps in one clock. The register is preset to all ones when a frame begins. The last nibble of the frame is part of the check. In the next cycle the block raises a one-cycle strobe, and with it a pass or fail flag.

Control is a two-state machine. In `S_IDLE` no frame is open. In `S_FRAME` a frame is being accumulated. It has five named transitions:
- START (`S_IDLE` to `S_FRAME`): a valid nibble arrives without the last-nibble pulse.
- SINGLE (`S_IDLE` to `S_IDLE`): a valid nibble arrives with the last-nibble pulse, giving a one-nibble frame.
- CONTINUE (`S_FRAME` to `S_FRAME`): a valid nibble arrives without the pulse.
- END (`S_FRAME` to `S_IDLE`): a valid nibble arrives with the pulse.
- GAP (`S_FRAME` to `S_IDLE`): valid drops while a frame is open. The frame is abandoned and gets no verdict.

Whenever the machine is in `S_IDLE`, the next valid nibble is combined with the all-ones preset and not with the stored register.

Top module: `rx_fcs_nibble_check`

## Requirements
- R1: Each cycle with `nib_vld` high advances the CRC register. The four bits of `nib_data` are taken bit 0 first. Each bit XORs into register bit 31, and the register shifts toward the MSB with feedback polynomial 0x04C11DB7. Cycles with `nib_vld` low leave the register unchanged.
- R2: `last_pulse` marks the final nibble of a frame, and that nibble is included in the check.
- R3: `ok_vld` is high for exactly one cycle: the cycle after a clock edge that sampled `nib_vld` and `last_pulse` both high. At all other times it is low.
- R4: With `ok_vld` high, `crc_ok` is 1 when the register value after the final nibble equals 0xC704DD7B, and 0 otherwise. A frame whose last eight nibbles carry the inverted CRC of the preceding nibbles (register bit 31 first, each nibble bit 0 first) therefore passes, and any single flipped bit fails.
- R5: `crc_ok` is 0 whenever `ok_vld` is 0.
- R6: If `nib_vld` falls while a frame is open, the frame is abandoned without any strobe. The next valid nibble starts a new frame from the all-ones preset.
- R7: A valid nibble in the cycle directly after a final nibble starts a new frame from the preset. No idle cycle is needed between frames.
- R8: `last_pulse` sampled with `nib_vld` low produces no strobe and does not disturb the following frame.
- R9: While `rst_n` is low, `ok_vld` and `crc_ok` are 0. A reset in the middle of a frame discards it, and the next frame is checked from the preset.
- R10: A frame of a single nibble (valid and last in the same cycle from idle) still receives a verdict in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_data | input | 4 | Received nibble, bit 0 is earliest on the wire |
| nib_vld | input | 1 | Qualifies `nib_data` |
| last_pulse | input | 1 | High with the final nibble of a frame |
| crc_ok | output | 1 | 1 = frame check sequence correct, valid with `ok_vld` |
| ok_vld | output | 1 | One-cycle verdict strobe |

## Verification
The checker is fed frames of varied length and content, including one with no payload, each with a correctly built check sequence. Alongside these are frames with one bit flipped either in the payload or inside the check sequence, which separate a true residue comparison from a check that only looks at part of the frame. Back-to-back frames, frames broken by an idle cycle, stray last-nibble pulses without valid, and one-nibble frames exercise the preset and reinitialization paths. Without correct reinitialization, the second of two consecutive good frames would fail. A reset part way through a frame, followed by a clean frame, confirms that reset discards the partial frame.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;

    localparam int          CRC_W       = 32;
    localparam int          NIB_W       = 4;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FRAME = 1'b1
    } rx_state_t;

endpackage

// File: rtl/rxcrc_step.sv
// Combinational multi-bit CRC advance: DW serial steps unrolled, bit 0 first.
module rxcrc_step #(
    parameter int          W    = 32,
    parameter int          DW   = 4,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic [W-1:0]  crc_in,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  crc_out
);

    logic [W-1:0] stage [DW+1];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic fb;
        assign fb           = stage[i][W-1] ^ din[i];
        assign stage[i+1]   = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DW];

endmodule

// File: rtl/rxcrc_ctrl.sv
// Frame tracking state machine.
module rxcrc_ctrl
    import rxcrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nib_vld,
    input  logic last_pulse,
    output logic use_preset,
    output logic load_en,
    output logic report
);

    rx_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (nib_vld && !last_pulse) state_d = S_FRAME;   // START
                else                        state_d = S_IDLE;    // SINGLE or wait
            end
            S_FRAME: begin
                if (!nib_vld)               state_d = S_IDLE;    // GAP
                else if (last_pulse)        state_d = S_IDLE;    // END
                else                        state_d = S_FRAME;   // CONTINUE
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        use_preset = 1'b0;
        unique case (state_q)
            S_IDLE:  use_preset = 1'b1;
            S_FRAME: use_preset = 1'b0;
        endcase
        load_en = nib_vld;
        report  = nib_vld && last_pulse;
    end

    // R6: a dropped valid closes the open frame
    p_gap_closes_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FRAME && !nib_vld) |=> (state_q == S_IDLE));

endmodule

// File: rtl/rxcrc_accum.sv
// CRC accumulator register with preset selection.
module rxcrc_accum #(
    parameter int           W      = 32,
    parameter int           DW     = 4,
    parameter logic [W-1:0] POLY   = '0,
    parameter logic [W-1:0] PRESET = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_preset,
    input  logic          load_en,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  crc_next
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_src;

    assign crc_src = use_preset ? PRESET : crc_q;

    rxcrc_step #(.W(W), .DW(DW), .POLY(POLY)) u_step (
        .crc_in (crc_src),
        .din    (din),
        .crc_out(crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= PRESET;
        else if (load_en) crc_q <= crc_next;
    end

    // R1: register holds while no nibble is qualified
    p_hold_without_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(crc_q));

endmodule

// File: rtl/rxcrc_verdict.sv
// Registered pass/fail flag and strobe.
module rxcrc_verdict #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RESIDUE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         report,
    input  logic [W-1:0] crc_final,
    output logic         crc_ok,
    output logic         ok_vld
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_vld <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            ok_vld <= report;
            crc_ok <= report && (crc_final == RESIDUE);
        end
    end

    // R5: pass flag never stands alone
    p_ok_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_vld |-> !crc_ok);

endmodule

// File: rtl/rx_fcs_nibble_check.sv
module rx_fcs_nibble_check
    import rxcrc_pkg::*;
#(
    parameter int              W       = CRC_W,
    parameter int              DW      = NIB_W,
    parameter logic [W-1:0]    POLY    = CRC_POLY,
    parameter logic [W-1:0]    PRESET  = CRC_PRESET,
    parameter logic [W-1:0]    RESIDUE = CRC_RESIDUE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] nib_data,
    input  logic          nib_vld,
    input  logic          last_pulse,
    output logic          crc_ok,
    output logic          ok_vld
);

    logic         use_preset;
    logic         load_en;
    logic         report;
    logic [W-1:0] crc_next;

    rxcrc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_vld   (nib_vld),
        .last_pulse(last_pulse),
        .use_preset(use_preset),
        .load_en   (load_en),
        .report    (report)
    );

    rxcrc_accum #(.W(W), .DW(DW), .POLY(POLY), .PRESET(PRESET)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_preset(use_preset),
        .load_en   (load_en),
        .din       (nib_data),
        .crc_next  (crc_next)
    );

    rxcrc_verdict #(.W(W), .RESIDUE(RESIDUE)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .report   (report),
        .crc_final(crc_next),
        .crc_ok   (crc_ok),
        .ok_vld   (ok_vld)
    );

    // R3: a qualified last nibble is answered next cycle
    p_strobe_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_vld && last_pulse) |=> ok_vld);

    // R8: no strobe without a qualified last nibble
    p_no_stray_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nib_vld && last_pulse) |=> !ok_vld);

endmodule

// File: tb/tb_rx_fcs_nibble_check.sv
`timescale 1ns/100ps
module tb_rx_fcs_nibble_check;

    localparam logic [31:0] POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] RESIDUE = 32'hC704_DD7B;
    localparam int          MAXN    = 1024;

    // stimulus table: data length, seed, flipped nibble index (-1 none)
    localparam int NV = 6;
    localparam int T_LEN  [NV] = '{16, 120, 3, 40, 40, 0};
    localparam int T_SEED [NV] = '{11, 22, 33, 44, 55, 66};
    localparam int T_FLIP [NV] = '{-1, -1, -1, 5, 46, -1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nib_data = 4'h0;
    logic       nib_vld = 1'b0;
    logic       last_pulse = 1'b0;
    logic       crc_ok;
    logic       ok_vld;

    int checks = 0;
    int fails  = 0;

    logic [3:0] fd [MAXN];
    bit         fv [MAXN];
    bit         fe [MAXN];
    bit         fx [MAXN];
    int         wp = 0;

    always #2.5 clk = ~clk;

    rx_fcs_nibble_check dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_data  (nib_data),
        .nib_vld   (nib_vld),
        .last_pulse(last_pulse),
        .crc_ok    (crc_ok),
        .ok_vld    (ok_vld)
    );

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int s, input int e);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = s; i < e; i++) begin
            for (int b = 0; b < 4; b++) begin
                logic f;
                f = c[31] ^ fd[i][b];
                c = {c[30:0], 1'b0} ^ (f ? POLY : 32'h0);
            end
        end
        return c;
    endfunction

    task automatic append_raw(input logic [3:0] d, input bit v, input bit e);
        fd[wp] = d; fv[wp] = v; fe[wp] = e; fx[wp] = 1'b0;
        if (v && e) fx[wp] = (ref_crc(wp, wp + 1) == RESIDUE);
        wp++;
    endtask

    task automatic append_idle(input int k);
        for (int i = 0; i < k; i++) append_raw(4'h0, 1'b0, 1'b0);
    endtask

    task automatic append_frame(input int len, input int seed, input int flip);
        int          s = wp;
        logic [15:0] x = 16'(seed);
        logic [31:0] c;
        for (int i = 0; i < len; i++) begin
            x = x * 16'd25173 + 16'd13849;
            fd[wp] = x[11:8]; fv[wp] = 1'b1; fe[wp] = 1'b0; fx[wp] = 1'b0;
            wp++;
        end
        c = ref_crc(s, wp);
        for (int k = 0; k < 8; k++) begin
            logic [3:0] n;
            for (int b = 0; b < 4; b++) n[b] = ~c[31 - 4*k - b];
            fd[wp] = n; fv[wp] = 1'b1; fe[wp] = 1'b0; fx[wp] = 1'b0;
            wp++;
        end
        if (flip >= 0) fd[s + flip] = fd[s + flip] ^ 4'h1;
        fe[wp-1] = 1'b1;
        fx[wp-1] = (ref_crc(s, wp) == RESIDUE);
    endtask

    // drive the prepared stream and compare every cycle's outputs
    task automatic play(input string tag);
        for (int i = 0; i <= wp; i++) begin
            @(negedge clk);
            if (i > 0) begin
                bit ev;
                ev = fv[i-1] && fe[i-1];
                chk(ok_vld == ev, {"R3 strobe ", tag}, 32'(ok_vld), 32'(ev));
                if (ev) chk(crc_ok == fx[i-1], {"R4 verdict ", tag}, 32'(crc_ok), 32'(fx[i-1]));
                else    chk(crc_ok == 1'b0,   {"R5 idle flag ", tag}, 32'(crc_ok), 32'h0);
            end
            if (i < wp) begin
                nib_data = fd[i]; nib_vld = fv[i]; last_pulse = fe[i];
            end else begin
                nib_data = 4'h0; nib_vld = 1'b0; last_pulse = 1'b0;
            end
        end
        wp = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (2) @(negedge clk);
        chk(ok_vld == 1'b0, "R9 reset strobe", 32'(ok_vld), 32'h0);
        chk(crc_ok == 1'b0, "R9 reset flag", 32'(crc_ok), 32'h0);
        rst_n = 1'b1;

        // table of frames: R1 R2 R4 good and corrupted frames
        for (int t = 0; t < NV; t++) begin
            append_idle(1);
            append_frame(T_LEN[t], T_SEED[t], T_FLIP[t]);
            chk(fx[wp-1] == (T_FLIP[t] < 0), "R1 reference frame build", 32'(fx[wp-1]), 32'(T_FLIP[t] < 0));
            play("R1/R2 table");
        end

        // R2: pulse one nibble early excludes last FCS nibble -> fails
        append_frame(20, 7, -1);
        fe[wp-1] = 1'b0; fe[wp-2] = 1'b1; fx[wp-2] = 1'b0;
        fv[wp-1] = 1'b0;
        play("R2 early last");

        // R6: open frame abandoned by gap, then a clean frame
        append_frame(30, 8, -1);
        wp -= 8;
        append_idle(1);
        append_frame(24, 9, -1);
        play("R6 gap reinit");

        // R7: back-to-back frames, good, bad, good
        append_frame(12, 10, -1);
        append_frame(18, 12, 3);
        append_frame(9, 13, -1);
        append_idle(2);
        play("R7 back to back");

        // R8: stray last pulse without valid, in idle and after data
        append_raw(4'hF, 1'b0, 1'b1);
        append_frame(14, 14, -1);
        append_raw(4'h3, 1'b0, 1'b1);
        append_frame(5, 15, -1);
        play("R8 stray pulse");

        // R10: single nibble frames, then a normal one
        append_idle(1);
        append_raw(4'hA, 1'b1, 1'b1);
        append_raw(4'h0, 1'b1, 1'b1);
        append_frame(6, 16, -1);
        play("R10 single nibble");

        // R9: reset mid-frame
        append_frame(10, 17, -1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            nib_data = fd[i]; nib_vld = 1'b1; last_pulse = 1'b0;
        end
        wp = 0;
        @(negedge clk);
        rst_n = 1'b0; nib_vld = 1'b0;
        @(negedge clk);
        chk(ok_vld == 1'b0, "R9 mid reset strobe", 32'(ok_vld), 32'h0);
        chk(crc_ok == 1'b0, "R9 mid reset flag", 32'(crc_ok), 32'h0);
        rst_n = 1'b1;
        append_frame(22, 18, -1);
        play("R9 after reset");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule